// File: doc/BRIEF.md
# Banked Level Interrupt Controller with Shortcut Mirrors

This block gathers 72 level-sensitive interrupt sources into three banks and presents them to one processor through a small 32-bit register window. The first bank holds 8 basic sources. The other two banks hold 32 sources each. Every bank has its own enable mask. Software sets mask bits through one offset and clears them through another. A pending word shows which enabled sources are asserted. The processor sees a single IRQ line.

The first bank's pending word also summarises the two wide banks. A summary bit says that some ordinary source in that bank is pending. A group of shortcut bits copies eleven frequently used wide-bank sources directly, so a handler can often decode the interrupt with one read. A source that has a shortcut never raises its bank's summary bit. Neither the summary bits nor the shortcut bits have an enable of their own in the first bank.

A separate control register can steer one chosen source to a fast-interrupt output. That source then drives the fast output directly and is taken out of the IRQ.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset every enable bit is 0 and the fast-route control reads 0. All three pending words read 0, and `irq_o` and `fiq_o` are low, whatever the source levels are.
- R2: A write to an enable offset sets every enable bit whose data bit is 1 and leaves the others as they were. The enable offsets are 0x18 for bank 0, 0x10 for bank 1 and 0x14 for bank 2. Reading either the enable or the disable offset of a bank returns that bank's current mask.
- R3: A write to a disable offset clears every enable bit whose data bit is 1 and leaves the others as they were. The disable offsets are 0x24 for bank 0, 0x1c for bank 1 and 0x20 for bank 2.
- R4: The pending words of bank 1 (offset 0x04) and bank 2 (offset 0x08) equal the source levels ANDed with the bank's enable mask, on the same cycle. Bank 1 is `src_i[31:0]` and bank 2 is `src_i[63:32]`.
- R5: Bits 7:0 of the bank 0 pending word (offset 0x00) equal the bank 0 sources `src_i[71:64]` ANDed with the bank 0 mask.
- R6: Bank 0 pending bits 14:10 copy the bank 1 pending bits 7, 9, 10, 18 and 19, in that order from bit 10 upward. Bits 20:15 copy the bank 2 pending bits 21, 22, 23, 24, 25 and 30, in that order from bit 15 upward.
- R7: Bank 0 pending bit 8 is 1 exactly when some enabled, pending bank 1 source without a shortcut exists. Bit 9 is 1 under the same condition for bank 2. A pending shortcut source never sets bit 8 or bit 9.
- R8: The bank 0 mask has only 8 bits. Data bits 31:8 written to offset 0x18 or 0x24 are ignored, so the summary and shortcut bits cannot be masked there. Bank 0 pending bits 31:21 read 0.
- R9: The fast-route control at offset 0x0c keeps a 7-bit source index in bits 6:0 and an enable flag in bit 7. Bits 31:8 read as 0.
- R10: When the enable flag is set, `fiq_o` equals the raw level of the indexed source, whatever that source's enable bit is. Indices 0-31 select bank 1, 32-63 select bank 2 and 64-71 select bank 0 bits 0-7. An index of 72 or more, or a cleared flag, holds `fiq_o` low.
- R11: `irq_o` is the OR of all enabled, pending sources, leaving out the source that the fast route currently selects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register window |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_i | input | 72 | Source levels: bank 1 in 31:0, bank 2 in 63:32, bank 0 in 71:64 |
| irq_o | output | 1 | Ordinary interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench first drives a wide bank full of asserted sources under a partial mask. This separates mask gating from summary generation. Patterns that contain only shortcut sources, and single-bit patterns on each shortcut position, check the mirror ordering and confirm that the summary bit stays clear. Writes with high data bits to the bank 0 mask offsets show that nothing above bit 7 takes effect there. Fast-route tests use a disabled source, a source that is both enabled and routed, and indices in every bank and beyond 71. Together they tell apart raw routing, IRQ exclusion and out-of-range handling.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NBANK     = 3;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int BASIC_W   = 8;
  localparam int WIDE_W    = 32;
  localparam int NSRC      = BASIC_W + 2 * WIDE_W;
  localparam int FIQ_IDX_W = 7;
  localparam int FIQ_CTL_W = FIQ_IDX_W + 1;
  localparam int NSC1      = 5;
  localparam int NSC2      = 6;
  localparam int SUM_BIT   = BASIC_W;
  localparam int SC_BASE   = BASIC_W + 2;

  typedef logic [DATA_W-1:0] word_t;

  function automatic int bank_width(input int b);
    return (b == 0) ? BASIC_W : WIDE_W;
  endfunction

  // position of a bank inside the flat source vector (fast-route index order)
  function automatic int src_base(input int b);
    return (b == 1) ? 0 : (b == 2) ? WIDE_W : 2 * WIDE_W;
  endfunction

  function automatic logic [ADDR_W-1:0] pend_off(input int b);
    return ADDR_W'(4 * b);
  endfunction

  function automatic logic [ADDR_W-1:0] en_off(input int b);
    return (b == 0) ? 8'h18 : (b == 1) ? 8'h10 : 8'h14;
  endfunction

  function automatic logic [ADDR_W-1:0] dis_off(input int b);
    return (b == 0) ? 8'h24 : (b == 1) ? 8'h1c : 8'h20;
  endfunction

  localparam logic [ADDR_W-1:0] FIQ_OFF = 8'h0c;

  // wide-bank source carried by shortcut k (k counts from bank 1 upward)
  function automatic int sc_src(input int k);
    case (k)
      0: return 7;
      1: return 9;
      2: return 10;
      3: return 18;
      4: return 19;
      5: return 21;
      6: return 22;
      7: return 23;
      8: return 24;
      9: return 25;
      default: return 30;
    endcase
  endfunction

  function automatic word_t sc_mask(input int b);
    word_t m;
    m = '0;
    for (int k = 0; k < NSC1 + NSC2; k++) begin
      if ((b == 1 && k < NSC1) || (b == 2 && k >= NSC1)) m[sc_src(k)] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/irqc_enable_bank.sv
module irqc_enable_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= (en_q | set_i) & ~clr_i;
  end

  assign en_o = en_q;
endmodule

// File: rtl/irqc_basic_word.sv
module irqc_basic_word
  import irqc_pkg::*;
(
  input  logic [BASIC_W-1:0] pend0_i,
  input  word_t              pend1_i,
  input  word_t              pend2_i,
  output word_t              word_o
);
  localparam word_t MASK1 = sc_mask(1);
  localparam word_t MASK2 = sc_mask(2);

  logic [NSC1+NSC2-1:0] sc_bits;

  for (genvar k = 0; k < NSC1 + NSC2; k++) begin : g_sc
    if (k < NSC1) begin : g_b1
      assign sc_bits[k] = pend1_i[sc_src(k)];
    end else begin : g_b2
      assign sc_bits[k] = pend2_i[sc_src(k)];
    end
  end

  logic sum1, sum2;
  assign sum1 = |(pend1_i & ~MASK1);
  assign sum2 = |(pend2_i & ~MASK2);

  always_comb begin
    word_o = '0;
    word_o[BASIC_W-1:0] = pend0_i;
    word_o[SUM_BIT]     = sum1;
    word_o[SUM_BIT+1]   = sum2;
    word_o[SC_BASE +: NSC1+NSC2] = sc_bits;
  end
endmodule

// File: rtl/irqc_fiq_route.sv
module irqc_fiq_route
  import irqc_pkg::*;
(
  input  logic [FIQ_CTL_W-1:0] ctl_i,
  input  logic [NSRC-1:0]      src_i,
  output logic                 fiq_o,
  output logic [NSRC-1:0]      route_o
);
  logic [FIQ_IDX_W-1:0] idx;
  logic                 on;
  assign idx = ctl_i[FIQ_IDX_W-1:0];
  assign on  = ctl_i[FIQ_IDX_W];

  for (genvar i = 0; i < NSRC; i++) begin : g_sel
    assign route_o[i] = on && (idx == FIQ_IDX_W'(i));
  end

  assign fiq_o = |(route_o & src_i);
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   src_i,
  output logic              irq_o,
  output logic              fiq_o
);
  word_t en_word   [NBANK];
  word_t pend_word [NBANK];
  logic [NSRC-1:0] en_flat;
  logic [NSRC-1:0] pend_flat;
  logic [NSRC-1:0] route;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int W = bank_width(b);
    localparam int B = src_base(b);
    logic [W-1:0] set_v, clr_v, en_v;
    assign set_v = (bus_wr && bus_addr == en_off(b))  ? bus_wdata[W-1:0] : '0;
    assign clr_v = (bus_wr && bus_addr == dis_off(b)) ? bus_wdata[W-1:0] : '0;
    irqc_enable_bank #(.W(W)) u_en (
      .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v), .en_o(en_v)
    );
    assign en_flat[B +: W] = en_v;
    assign en_word[b]      = DATA_W'(en_v);
    if (b != 0) begin : g_wide
      assign pend_word[b] = DATA_W'(pend_flat[B +: W]);
    end
  end

  assign pend_flat = src_i & en_flat;

  irqc_basic_word u_word (
    .pend0_i(pend_flat[src_base(0) +: BASIC_W]),
    .pend1_i(pend_word[1]),
    .pend2_i(pend_word[2]),
    .word_o (pend_word[0])
  );

  logic [FIQ_CTL_W-1:0] fiq_ctl_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                            fiq_ctl_q <= '0;
    else if (bus_wr && bus_addr == FIQ_OFF) fiq_ctl_q <= bus_wdata[FIQ_CTL_W-1:0];
  end

  logic fiq_w;
  irqc_fiq_route u_fiq (
    .ctl_i(fiq_ctl_q), .src_i(src_i), .fiq_o(fiq_w), .route_o(route)
  );

  assign fiq_o = fiq_w;
  assign irq_o = |(pend_flat & ~route);

  // named views for the checker
  word_t en_b1, pend_w0, pend_w1, pend_w2;
  assign en_b1   = en_word[1];
  assign pend_w0 = pend_word[0];
  assign pend_w1 = pend_word[1];
  assign pend_w2 = pend_word[2];

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (bus_addr == pend_off(b)) bus_rdata = pend_word[b];
      if (bus_addr == en_off(b) || bus_addr == dis_off(b)) bus_rdata = en_word[b];
    end
    if (bus_addr == FIQ_OFF) bus_rdata = DATA_W'(fiq_ctl_q);
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input word_t             en_b1,
  input word_t             pend_w0,
  input word_t             pend_w1,
  input word_t             pend_w2,
  input logic [FIQ_CTL_W-1:0] fiq_ctl_q,
  input logic              irq_o,
  input logic              fiq_o
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq_o && !fiq_o && en_b1 == '0));

  a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h10) |=> ((en_b1 & $past(bus_wdata)) == $past(bus_wdata)));

  a_r3_clear_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h1c) |=> ((en_b1 & $past(bus_wdata)) == '0));

  a_r6_mirror_first: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_w0[10] == pend_w1[7]) && (pend_w0[20] == pend_w2[30]));

  a_r7_summary_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_w1 == '0) |-> !pend_w0[8]);

  a_r8_high_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pend_w0[31:21] == '0);

  a_r10_fiq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !fiq_ctl_q[FIQ_IDX_W] |-> !fiq_o);

  a_r11_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_w1 == '0 && pend_w2 == '0 && pend_w0[7:0] == '0) |-> !irq_o);
endmodule

bind irq_bank_ctrl irqc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .en_b1(en_b1), .pend_w0(pend_w0), .pend_w1(pend_w1),
  .pend_w2(pend_w2), .fiq_ctl_q(fiq_ctl_q), .irq_o(irq_o), .fiq_o(fiq_o)
);

// File: tb/tb_irq_bank_ctrl.sv
module tb_irq_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [71:0] src_i = '0;
  logic        irq_o, fiq_o;

  irq_bank_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_i(src_i),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  always #2 clk = ~clk;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  event  sample_ev;
  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 0;

  // monitor: pops the next expectation and compares with the live output
  initial begin
    forever begin
      item_t it;
      logic [31:0] act;
      @(sample_ev);
      it = q.pop_front();
      act = (it.kind == 0) ? bus_rdata : (it.kind == 1) ? {31'b0, irq_o} : {31'b0, fiq_o};
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push(input int kind, input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
    ->sample_ev;
    #1;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    push(0, exp, tag);
  endtask

  task automatic pin(input int kind, input bit exp, input string tag);
    @(negedge clk);
    #1;
    push(kind, {31'b0, exp}, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic drive(input logic [71:0] s);
    @(negedge clk);
    src_i = s;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    src_i = '1;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state with every source high
    rd(8'h00, 32'h0, "R1 pend0");
    rd(8'h04, 32'h0, "R1 pend1");
    rd(8'h08, 32'h0, "R1 pend2");
    rd(8'h0c, 32'h0, "R1 fiq ctl");
    rd(8'h10, 32'h0, "R1 en1");
    pin(1, 1'b0, "R1 irq");
    pin(2, 1'b0, "R1 fiq");
    drive('0);
    // R2 / R3 set and clear
    wr(8'h10, 32'h0000_00FF);
    rd(8'h10, 32'h0000_00FF, "R2 en1 via enable offset");
    rd(8'h1c, 32'h0000_00FF, "R2 en1 via disable offset");
    wr(8'h10, 32'h0000_0100);
    rd(8'h10, 32'h0000_01FF, "R2 zero bits keep value");
    wr(8'h1c, 32'h0000_000F);
    rd(8'h10, 32'h0000_01F0, "R3 disable clears");
    // R4 / R7 partial mask, all bank 1 sources high
    drive({8'h00, 32'h0, 32'hFFFF_FFFF});
    rd(8'h04, 32'h0000_01F0, "R4 pend1 masked");
    rd(8'h00, 32'h0000_0500, "R7 summary plus shortcut");
    pin(1, 1'b1, "R11 irq from bank1");
    // R6 shortcut-only pattern
    wr(8'h10, 32'hFFFF_FFFF);
    drive({8'h00, 32'h0, 32'h000C_0680});
    rd(8'h04, 32'h000C_0680, "R4 pend1 shortcuts");
    rd(8'h00, 32'h0000_7C00, "R7 shortcuts leave summary clear");
    drive({8'h00, 32'h0, 32'h0000_0200});
    rd(8'h00, 32'h0000_0800, "R6 bank1 src9 to bit11");
    drive({8'h00, 32'h0, 32'h0008_0000});
    rd(8'h00, 32'h0000_4000, "R6 bank1 src19 to bit14");
    // bank 2
    wr(8'h14, 32'hFFFF_FFFF);
    drive({8'h00, 32'h4000_0000, 32'h0});
    rd(8'h08, 32'h4000_0000, "R4 pend2");
    rd(8'h00, 32'h0010_0000, "R6 bank2 src30 to bit20");
    drive({8'h00, 32'h0020_0000, 32'h0});
    rd(8'h00, 32'h0000_8000, "R6 bank2 src21 to bit15");
    drive({8'h00, 32'h0000_0001, 32'h0});
    rd(8'h00, 32'h0000_0200, "R7 bank2 summary");
    drive({8'h00, 32'h43E0_0000, 32'h0});
    rd(8'h00, 32'h001F_8000, "R7 bank2 shortcuts only");
    // bank 0
    drive('0);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, 32'h0000_00FF, "R8 en0 only 8 bits");
    rd(8'h24, 32'h0000_00FF, "R2 en0 via disable offset");
    drive({8'hA5, 32'h0, 32'h0});
    rd(8'h00, 32'h0000_00A5, "R5 basic sources");
    wr(8'h24, 32'h0000_000F);
    rd(8'h00, 32'h0000_00A0, "R5 basic masked");
    // R8 bank 0 cannot mask or unmask summary/shortcut bits
    wr(8'h1c, 32'h0000_0080);
    drive({8'h00, 32'h0, 32'h0000_0090});
    rd(8'h00, 32'h0000_0100, "R8 shortcut off in own bank");
    wr(8'h18, 32'h0000_0400);
    rd(8'h00, 32'h0000_0100, "R8 bank0 enable no effect");
    rd(8'h18, 32'h0000_00F0, "R8 en0 unchanged");
    wr(8'h24, 32'h0000_0300);
    rd(8'h00, 32'h0000_0100, "R8 summary not maskable");
    pin(1, 1'b1, "R11 irq summary source");
    drive('0);
    pin(1, 1'b0, "R11 irq no sources");
    // fast route
    wr(8'h0c, 32'hFFFF_FF85);
    rd(8'h0c, 32'h0000_0085, "R9 fiq ctl width");
    wr(8'h1c, 32'h0000_0020);
    drive({8'h00, 32'h0, 32'h0000_0020});
    pin(2, 1'b1, "R10 fiq raw disabled src");
    pin(1, 1'b0, "R11 irq disabled src");
    wr(8'h10, 32'h0000_0020);
    pin(2, 1'b1, "R10 fiq enabled src");
    pin(1, 1'b0, "R11 routed src excluded");
    wr(8'h0c, 32'h0000_0005);
    pin(2, 1'b0, "R10 flag clear");
    pin(1, 1'b1, "R11 unrouted src to irq");
    rd(8'h0c, 32'h0000_0005, "R9 fiq ctl readback");
    wr(8'h0c, 32'h0000_00C3);
    drive({8'h08, 32'h0, 32'h0});
    pin(2, 1'b1, "R10 index 67 bank0 bit3");
    pin(1, 1'b0, "R11 bank0 bit3 disabled");
    wr(8'h0c, 32'h0000_00A8);
    drive({8'h00, 32'h0000_0100, 32'h0});
    pin(2, 1'b1, "R10 index 40 bank2 bit8");
    pin(1, 1'b0, "R11 bank2 routed excluded");
    wr(8'h0c, 32'h0000_00E4);
    drive('1);
    pin(2, 1'b0, "R10 index beyond 71");
    pin(1, 1'b1, "R11 irq all sources");
    drive({8'h10, 32'h0, 32'h0});
    pin(1, 1'b1, "R11 irq bank0 source");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule